// File: doc/BRIEF.md
# Fine/Coarse Thread Select Unit

This unit decides, cycle by cycle, which of three hardware thread contexts feeds the next instruction into a single-issue pipeline front end. It owns one program counter for each thread and presents the chosen thread number, that thread's PC and an issue-valid flag. A thread's PC advances by a fixed step whenever that thread issues. A per-thread redirect port loads a new PC at any time.

A static mode input chooses between two policies. In interleaved (fine) mode the unit rotates round-robin across the threads on every clock and passes over any thread that reports a stall. In sticky (coarse) mode it stays on one thread until that thread reports a stall whose remaining length exceeds a threshold. It then raises a one-cycle flush request, moves to the next ready thread in circular order, and holds issue off for a parameterised number of refill cycles.

The controller is a three-state machine. `SEL_FINE` is the interleaved state. `SEL_RUN` issues from the current thread in sticky mode. `SEL_REFILL` counts the refill penalty. `SEL_RUN` moves to `SEL_REFILL` on a costly stall when another thread is ready, and `SEL_REFILL` returns to `SEL_RUN` when its counter reaches zero. A mode input that disagrees with the state moves the machine between `SEL_FINE` and `SEL_RUN`. Reset enters whichever of those two states the mode input selects.

Top module: `tsel_unit`

## Requirements
- R1: A synchronous reset selects thread 0, sets the rotation start pointer to 0 and loads every thread's PC from its reset-vector input. In the first cycle after reset, `sel_tid` is 0 and `sel_pc` equals thread 0's reset vector.
- R2: In fine mode the chosen thread is the first non-stalled thread found by scanning from the rotation pointer in increasing circular order. After an issue the pointer moves to the thread after the one issued, so with no stalls the selection cycles 0,1,2,0,...
- R3: In fine mode a stalled thread is never selected. `issue_valid` is high only when the thread shown on `sel_tid` has its stall bit low.
- R4: When every thread is stalled in fine mode, `issue_valid` is low, `sel_tid` shows the pointer, and the pointer keeps its value.
- R5: When a thread issues (`issue_valid` high), its PC grows by INC (4) at the next edge. Every other thread's PC is unchanged.
- R6: A redirect on thread t loads `redir_pc[t]` into that thread's PC at the next edge. A redirect takes priority over the issue increment.
- R7: In coarse mode the selected thread stays the same on every cycle without a flush. A stall whose remaining count is 2 or less only drops `issue_valid`.
- R8: In coarse mode, a stall on the current thread with remaining count above 2 raises `flush_req` for exactly one cycle, provided another thread is ready. In that cycle `issue_valid` is low, and the next thread is the first ready one after the current thread in circular order.
- R9: After a coarse switch, `issue_valid` stays low for REFILL_CYC (3) further cycles. The new thread then issues.
- R10: In coarse mode a costly stall with no other ready thread causes no flush and keeps the current thread.
- R11: `flush_req` is never asserted in fine mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_coarse | input | 1 | Static policy select: 0 = fine, 1 = coarse |
| rst_vec | input | NTHR x PCW | Per-thread PC reset vector |
| stall_i | input | NTHR | Per-thread stall flag |
| stall_left_i | input | NTHR x CW | Per-thread remaining stall cycles |
| redir_v | input | NTHR | Per-thread PC redirect strobe |
| redir_pc | input | NTHR x PCW | Per-thread redirect target |
| sel_tid | output | TW | Selected thread number |
| sel_pc | output | PCW | PC of the selected thread |
| issue_valid | output | 1 | An instruction from `sel_tid` is issued this cycle |
| flush_req | output | 1 | One-cycle pipeline flush request on a coarse switch |

## Verification
The bound checker watches several rules on every cycle. It confirms that a valid issue never names a stalled thread and that nothing issues while all threads stall. It confirms that a flush lasts one cycle, changes the selection and suppresses issue, that the coarse selection only moves through a flush, and that fine mode never flushes. The scenarios alone can show the exact rotation order and the behaviour of the pointer after an all-stall period. The same holds for per-thread PC arithmetic with redirect priority, the length of the refill window, the circular choice of the next thread and the effect of the threshold. The bench's behavioural reference model is compared against the outputs on every clock.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
    typedef enum logic [1:0] {
        SEL_FINE   = 2'd0,
        SEL_RUN    = 2'd1,
        SEL_REFILL = 2'd2
    } sel_state_e;
endpackage

// File: rtl/tsel_rr_pick.sv
module tsel_rr_pick #(
    parameter int NTHR = 3,
    parameter int TW   = $clog2(NTHR)
) (
    input  logic [NTHR-1:0] ready,
    input  logic [TW-1:0]   start,
    output logic            found,
    output logic [TW-1:0]   idx
);
    int j;
    always_comb begin
        found = 1'b0;
        idx   = start;
        j     = 0;
        // scan backwards so the smallest circular distance wins
        for (int k = NTHR - 1; k >= 0; k--) begin
            j = int'(start) + k;
            if (j >= NTHR) j = j - NTHR;
            if (ready[TW'(j)]) begin
                found = 1'b1;
                idx   = TW'(j);
            end
        end
    end
endmodule

// File: rtl/tsel_pc_bank.sv
module tsel_pc_bank #(
    parameter int NTHR = 3,
    parameter int TW   = $clog2(NTHR),
    parameter int PCW  = 32,
    parameter int INC  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NTHR-1:0][PCW-1:0]  rst_vec,
    input  logic [NTHR-1:0]           redir_v,
    input  logic [NTHR-1:0][PCW-1:0]  redir_pc,
    input  logic                      adv_v,
    input  logic [TW-1:0]             adv_tid,
    input  logic [TW-1:0]             rd_tid,
    output logic [PCW-1:0]            rd_pc
);
    localparam logic [PCW-1:0] STEP = PCW'(INC);

    logic [NTHR-1:0][PCW-1:0] pc_q;

    for (genvar g = 0; g < NTHR; g++) begin : g_ctx
        always_ff @(posedge clk) begin
            if (rst)
                pc_q[g] <= rst_vec[g];
            else if (redir_v[g])
                pc_q[g] <= redir_pc[g];
            else if (adv_v && adv_tid == TW'(g))
                pc_q[g] <= pc_q[g] + STEP;
        end
    end

    assign rd_pc = pc_q[rd_tid];
endmodule

// File: rtl/tsel_unit.sv
module tsel_unit
    import tsel_pkg::*;
#(
    parameter int NTHR       = 3,
    parameter int PCW        = 32,
    parameter int INC        = 4,
    parameter int CW         = 4,
    parameter int LONG_TH    = 2,
    parameter int REFILL_CYC = 3,
    parameter int TW         = $clog2(NTHR)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      mode_coarse,
    input  logic [NTHR-1:0][PCW-1:0]  rst_vec,
    input  logic [NTHR-1:0]           stall_i,
    input  logic [NTHR-1:0][CW-1:0]   stall_left_i,
    input  logic [NTHR-1:0]           redir_v,
    input  logic [NTHR-1:0][PCW-1:0]  redir_pc,
    output logic [TW-1:0]             sel_tid,
    output logic [PCW-1:0]            sel_pc,
    output logic                      issue_valid,
    output logic                      flush_req
);
    localparam int RCW = $clog2(REFILL_CYC + 1);
    localparam logic [CW-1:0]  LONG_LIM  = CW'(LONG_TH);
    localparam logic [RCW-1:0] RLOAD     = RCW'(REFILL_CYC - 1);
    localparam logic [TW-1:0]  LAST_TID  = TW'(NTHR - 1);

    sel_state_e       state_q, state_d;
    logic [TW-1:0]    ptr_q, ptr_d;
    logic [TW-1:0]    cur_q, cur_d;
    logic [RCW-1:0]   rcnt_q, rcnt_d;

    logic [NTHR-1:0]  ready;
    logic [NTHR-1:0]  other_ready;
    logic [TW-1:0]    cur_next;
    logic             fine_found, co_found;
    logic [TW-1:0]    fine_idx, co_idx;

    assign ready       = ~stall_i;
    assign other_ready = ready & ~(NTHR'(1) << cur_q);
    assign cur_next    = (cur_q == LAST_TID) ? '0 : cur_q + 1'b1;

    tsel_rr_pick #(.NTHR(NTHR), .TW(TW)) u_fine_pick (
        .ready (ready),
        .start (ptr_q),
        .found (fine_found),
        .idx   (fine_idx)
    );

    tsel_rr_pick #(.NTHR(NTHR), .TW(TW)) u_coarse_pick (
        .ready (other_ready),
        .start (cur_next),
        .found (co_found),
        .idx   (co_idx)
    );

    tsel_pc_bank #(.NTHR(NTHR), .TW(TW), .PCW(PCW), .INC(INC)) u_pcs (
        .clk      (clk),
        .rst      (rst),
        .rst_vec  (rst_vec),
        .redir_v  (redir_v),
        .redir_pc (redir_pc),
        .adv_v    (issue_valid),
        .adv_tid  (sel_tid),
        .rd_tid   (sel_tid),
        .rd_pc    (sel_pc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= mode_coarse ? SEL_RUN : SEL_FINE;
            ptr_q   <= '0;
            cur_q   <= '0;
            rcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            cur_q   <= cur_d;
            rcnt_q  <= rcnt_d;
        end
    end

    // outputs and next state
    always_comb begin
        state_d     = state_q;
        ptr_d       = ptr_q;
        cur_d       = cur_q;
        rcnt_d      = rcnt_q;
        sel_tid     = cur_q;
        issue_valid = 1'b0;
        flush_req   = 1'b0;
        unique case (state_q)
            SEL_FINE: begin
                sel_tid     = fine_idx;
                issue_valid = fine_found;
                if (fine_found)
                    ptr_d = (fine_idx == LAST_TID) ? '0 : fine_idx + 1'b1;
                if (mode_coarse)
                    state_d = SEL_RUN;
            end
            SEL_RUN: begin
                if (!stall_i[cur_q]) begin
                    issue_valid = 1'b1;
                end else if (stall_left_i[cur_q] > LONG_LIM && co_found) begin
                    flush_req = 1'b1;
                    cur_d     = co_idx;
                    rcnt_d    = RLOAD;
                    state_d   = SEL_REFILL;
                end
                if (!mode_coarse)
                    state_d = SEL_FINE;
            end
            SEL_REFILL: begin
                if (rcnt_q == '0)
                    state_d = SEL_RUN;
                else
                    rcnt_d = rcnt_q - 1'b1;
                if (!mode_coarse)
                    state_d = SEL_FINE;
            end
            default: state_d = SEL_FINE;
        endcase
    end
endmodule

// File: rtl/tsel_unit_chk.sv
module tsel_unit_chk #(
    parameter int NTHR = 3,
    parameter int TW   = $clog2(NTHR)
) (
    input logic            clk,
    input logic            rst,
    input logic            mode_coarse,
    input logic [NTHR-1:0] stall_i,
    input logic [TW-1:0]   sel_tid,
    input logic            issue_valid,
    input logic            flush_req
);
    a_r3_valid_not_stalled: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> !stall_i[sel_tid]);

    a_r4_all_stalled_idle: assert property (@(posedge clk) disable iff (rst)
        (&stall_i) |-> !issue_valid);

    a_r8_flush_one_cycle: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !flush_req);

    a_r8_flush_moves_thread: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> sel_tid != $past(sel_tid));

    a_r8_flush_no_issue: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> !issue_valid);

    a_r9_refill_no_issue: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !issue_valid);

    a_r7_coarse_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_coarse && !flush_req) |=> $stable(sel_tid));

    a_r11_fine_no_flush: assert property (@(posedge clk) disable iff (rst)
        !mode_coarse |-> !flush_req);
endmodule

bind tsel_unit tsel_unit_chk #(.NTHR(NTHR), .TW(TW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_coarse (mode_coarse),
    .stall_i     (stall_i),
    .sel_tid     (sel_tid),
    .issue_valid (issue_valid),
    .flush_req   (flush_req)
);

// File: tb/tsel_unit_bench.sv
module tsel_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 3;
    localparam int REFIL = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_coarse = 1'b0;
    logic [N-1:0][31:0] rst_vec;
    logic [N-1:0]       stall_i = '0;
    logic [N-1:0][3:0]  stall_left_i = '0;
    logic [N-1:0]       redir_v = '0;
    logic [N-1:0][31:0] redir_pc = '0;
    logic [1:0]  sel_tid;
    logic [31:0] sel_pc;
    logic        issue_valid, flush_req;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tsel_unit u_tsel_unit (
        .clk(clk), .rst(rst), .mode_coarse(mode_coarse), .rst_vec(rst_vec),
        .stall_i(stall_i), .stall_left_i(stall_left_i), .redir_v(redir_v),
        .redir_pc(redir_pc), .sel_tid(sel_tid), .sel_pc(sel_pc),
        .issue_valid(issue_valid), .flush_req(flush_req)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    int          m_ptr, m_cur, m_refill;
    logic [31:0] m_pc [N];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(logic coarse);
        @(negedge clk);
        rst = 1'b1; mode_coarse = coarse;
        stall_i = '0; stall_left_i = '0; redir_v = '0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ptr = 0; m_cur = 0; m_refill = 0;
        for (int t = 0; t < N; t++) m_pc[t] = rst_vec[t];
    endtask

    // one cycle: inputs already set after a falling edge
    task automatic step(string req);
        bit e_valid, e_flush;
        int e_sel, nxt;
        #1;
        e_valid = 0; e_flush = 0; e_sel = 0; nxt = 0;
        if (!mode_coarse) begin
            e_sel = m_ptr;
            for (int k = N - 1; k >= 0; k--)
                if (!stall_i[(m_ptr + k) % N]) begin e_sel = (m_ptr + k) % N; e_valid = 1; end
        end else begin
            e_sel = m_cur;
            if (m_refill == 0) begin
                if (!stall_i[m_cur]) e_valid = 1;
                else if (stall_left_i[m_cur] > 2) begin
                    for (int k = N - 1; k >= 1; k--)
                        if (!stall_i[(m_cur + k) % N]) begin nxt = (m_cur + k) % N; e_flush = 1; end
                end
            end
        end
        chk(req, "issue_valid", 32'(issue_valid), 32'(e_valid));
        chk(req, "flush_req", 32'(flush_req), 32'(e_flush));
        chk(req, "sel_tid", 32'(sel_tid), 32'(e_sel));
        chk(req, "sel_pc", sel_pc, m_pc[e_sel]);
        @(posedge clk);
        for (int t = 0; t < N; t++) begin
            if (redir_v[t]) m_pc[t] = redir_pc[t];
            else if (e_valid && e_sel == t) m_pc[t] = m_pc[t] + 32'd4;
        end
        if (!mode_coarse) begin
            if (e_valid) m_ptr = (e_sel + 1) % N;
        end else if (m_refill > 0) m_refill--;
        else if (e_flush) begin m_cur = nxt; m_refill = REFIL; end
        @(negedge clk);
    endtask

    task automatic drive(logic [N-1:0] st, logic [3:0] l0, logic [3:0] l1, logic [3:0] l2);
        stall_i = st;
        stall_left_i[0] = l0; stall_left_i[1] = l1; stall_left_i[2] = l2;
    endtask

    task automatic random_run(string req, int cycles);
        for (int c = 0; c < cycles; c++) begin
            for (int t = 0; t < N; t++) begin
                stall_i[t]      = ($urandom % 10) < 4;
                stall_left_i[t] = 4'($urandom % 7);
                redir_v[t]      = ($urandom % 16) == 0;
                redir_pc[t]     = {$urandom, 2'b00} & 32'h0000_fffc;
            end
            step(req);
        end
        redir_v = '0; stall_i = '0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        rst_vec[0] = 32'h100; rst_vec[1] = 32'h200; rst_vec[2] = 32'h300;

        // fine mode
        do_reset(1'b0);
        drive(3'b111, 0, 0, 0);
        step("R1");                     // reset state seen with all stalled
        chk("R1", "sel_tid_after_reset", 32'(sel_tid), 32'd0);
        chk("R1", "sel_pc_after_reset", sel_pc, 32'h100);
        drive(3'b000, 0, 0, 0);
        for (int c = 0; c < 6; c++) step("R2");           // 0,1,2,0,1,2 and PC steps R5
        drive(3'b010, 0, 5, 0);
        for (int c = 0; c < 4; c++) step("R3");           // thread 1 skipped
        drive(3'b111, 1, 1, 1);
        for (int c = 0; c < 3; c++) step("R4");           // pointer held
        drive(3'b011, 0, 0, 0);
        step("R4");                                         // resumes at 2
        drive(3'b000, 0, 0, 0);
        step("R5");
        redir_v = 3'b111; redir_pc[0] = 32'h800; redir_pc[1] = 32'h900; redir_pc[2] = 32'ha00;
        step("R6");                                         // redirect beats increment
        redir_v = '0;
        for (int c = 0; c < 3; c++) step("R6");
        random_run("R3", 400);

        // coarse mode
        do_reset(1'b1);
        drive(3'b000, 0, 0, 0);
        for (int c = 0; c < 4; c++) step("R7");
        drive(3'b001, 2, 0, 0);
        for (int c = 0; c < 2; c++) step("R7");           // short stall: no switch
        drive(3'b001, 5, 0, 0);
        step("R8");                                         // flush toward thread 1
        drive(3'b000, 0, 0, 0);
        for (int c = 0; c < 3; c++) step("R9");           // refill window
        step("R9");                                         // thread 1 issues
        drive(3'b110, 0, 6, 3);
        step("R8");                                         // wraps to thread 0
        drive(3'b000, 0, 0, 0);
        for (int c = 0; c < 4; c++) step("R9");
        drive(3'b111, 7, 7, 7);
        for (int c = 0; c < 3; c++) step("R10");          // no ready thread
        drive(3'b000, 0, 0, 0);
        step("R10");
        random_run("R8", 600);

        // back to fine to confirm no flush there
        do_reset(1'b0);
        random_run("R11", 200);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule